// File: doc/BRIEF.md
# Pulse Update Pacing FIFO

The block sits between an energy computation engine and the meter's pulse pins. The engine finishes a multiplexer frame and then emits its pulse-output updates in a short burst. Each update is a strobe plus the level the pulse pin should take. Applied directly, the pin edges would bunch together. This block stores each channel's updates in a small FIFO and releases them one per time slot. The slots are evenly spaced, so the edges spread across the frame. There are two identical channels: channel 0 carries the real-energy pulse and channel 1 carries the reactive-energy pulse.

At every frame sync the FIFOs are emptied and two configuration values are captured: the slot spacing, counted in units of four clocks, and the maximum pulse width. A spacing of zero turns pacing off, and updates then reach the pin on the next clock. Each channel has a width guard. It counts the low-level updates applied since the last high-level update. Once that count goes beyond twice the maximum width plus one, the guard forces the pin high until a high-level update arrives. A 2-bit select chooses what drives the optical transmit pin: a data input, either pulse channel, or a constant idle-high level.

Top module: `pulse_pace_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, both `pulse_n` bits read 1, both `fifo_ovf` bits read 0 and both FIFOs are empty. The captured spacing is zero after reset, so the block starts in pass-through mode.
- R2: `cfg_interval` and `cfg_maxwidth` are captured only on a clock edge where `frm_sync` is 1. Changing them at any other time has no effect until the next frame sync.
- R3: With a captured spacing I > 0, the k-th update stored after a frame sync at edge E0 is applied at edge E0 + 4·I·k, for k = 1, 2, .... Updates are applied one per slot and in the order they were written. A slot that finds the FIFO empty passes unused.
- R4: With a captured spacing of 0, an update strobed at one edge is applied to `pulse_n` at that same edge, so it is visible in the following cycle. Nothing is buffered in this mode.
- R5: A frame sync empties both FIFOs. An update strobe in the same cycle as `frm_sync` is discarded.
- R6: Each FIFO holds 8 updates. A write that arrives while the FIFO holds 8 and no slot releases an entry in that cycle is dropped, and it sets that channel's `fifo_ovf` bit. The bit stays set until reset.
- R7: An applied update with `upd_level` = 0 drives `pulse_n` low (active) and one with `upd_level` = 1 drives it high.
- R8: The guard counts low-level updates applied since the last high-level update. The update that makes this count exceed 2·M+1 (M = captured maximum width) forces `pulse_n` high. Further low-level updates leave it high. A high-level update clears the guard, and the next low-level update drives the pin low again.
- R9: The two channels are independent. Traffic on one never changes the other's `pulse_n` or `fifo_ovf`.
- R10: `opt_tx` follows `opt_data` when `opt_sel` = 0, `pulse_n[0]` when it is 1, `pulse_n[1]` when it is 2, and is constant 1 when it is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_sync | input | 1 | Multiplexer frame start: empties FIFOs, captures configuration |
| cfg_interval | input | 8 | Slot spacing in units of 4 clocks; 0 selects pass-through |
| cfg_maxwidth | input | 8 | Maximum width M; the guard limit is 2·M+1 updates |
| upd_strobe | input | 2 | Per-channel update strobe |
| upd_level | input | 2 | Per-channel level for the update (0 = low/active) |
| opt_sel | input | 2 | Optical transmit source select |
| opt_data | input | 1 | Serial data source for the optical pin |
| pulse_n | output | 2 | Active-low pulse outputs: bit 0 real, bit 1 reactive |
| opt_tx | output | 1 | Optical transmit output |
| fifo_ovf | output | 2 | Sticky per-channel FIFO overflow flags |

## Verification
Corrupted FIFO pointers or counts show up on `pulse_n` at the next slot edge, as a level out of order or a level released twice. A wrong slot timer shifts every edge by whole cycles relative to multiples of 4·I, and this is visible at the first slot after the sync. A guard counter that is off by one lets the pin go high one update early or late, which shows within 2·M+2 applied updates. A lost overflow flag is visible on the cycle after the ninth write. The bench sweeps spacings, width limits and select values. For each of these it predicts every cycle's pin level from the slot arithmetic.

// File: rtl/pulse_pace_pkg.sv
package pulse_pace_pkg;

    localparam int CH_NUM = 2;

    typedef struct packed {
        logic vld;
        logic lvl;
    } pace_upd_t;

    typedef enum logic [1:0] {
        OPT_SRC_DATA = 2'b00,
        OPT_SRC_CH0  = 2'b01,
        OPT_SRC_CH1  = 2'b10,
        OPT_SRC_IDLE = 2'b11
    } opt_src_e;

    function automatic pace_upd_t pick_update(
        input logic bypass,
        input logic strobe,
        input logic level,
        input logic slot,
        input logic head_ok,
        input logic head_level
    );
        pace_upd_t u;
        if (bypass) begin
            u.vld = strobe;
            u.lvl = level;
        end else begin
            u.vld = slot & head_ok;
            u.lvl = head_level;
        end
        return u;
    endfunction

endpackage

// File: rtl/pace_slot_timer.sv
module pace_slot_timer #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_sync,
    input  logic [IVL_W-1:0] ivl_new,
    input  logic [IVL_W-1:0] ivl_cur,
    output logic             slot
);
    localparam int TW = IVL_W + 2;

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] span_new;
    logic [TW-1:0] span_cur;

    assign span_new = {ivl_new, 2'b00} - TW'(1);
    assign span_cur = {ivl_cur, 2'b00} - TW'(1);

    // A slot fires when the down-counter has expired; the sync cycle never fires.
    assign slot = (tmr_q == '0) && !frm_sync && (ivl_cur != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (frm_sync) begin
            tmr_q <= span_new;
        end else if (tmr_q == '0) begin
            tmr_q <= span_cur;
        end else begin
            tmr_q <= tmr_q - TW'(1);
        end
    end

endmodule

// File: rtl/pace_fifo.sv
module pace_fifo #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             push_level,
    input  logic             pop,
    output logic             head_ok,
    output logic             head_level,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] store_q;
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             do_pop;
    logic             room;
    logic             do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_ok    = (cnt_q != '0);
    assign head_level = store_q[rd_q];
    assign do_pop     = pop && head_ok;
    assign room       = (cnt_q != CNT_W'(DEPTH)) || do_pop;
    assign do_push    = push && room;
    assign count      = cnt_q;
    assign ovf        = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else if (clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                store_q[wr_q] <= push_level;
                wr_q          <= bump(wr_q);
            end
            if (do_pop) begin
                rd_q <= bump(rd_q);
            end
            if (push && !room) begin
                ovf_q <= 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/pulse_width_guard.sv
module pulse_width_guard
    import pulse_pace_pkg::*;
#(
    parameter int MW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  pace_upd_t       upd,
    input  logic [MW_W-1:0] maxw,
    output logic            pulse_n
);
    localparam int CW = MW_W + 2;

    logic [CW-1:0] low_cnt_q;
    logic          forced_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    assign limit   = {1'b0, maxw, 1'b1};
    assign cnt_inc = low_cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_n   <= 1'b1;
            low_cnt_q <= '0;
            forced_q  <= 1'b0;
        end else if (upd.vld) begin
            if (upd.lvl) begin
                pulse_n   <= 1'b1;
                low_cnt_q <= '0;
                forced_q  <= 1'b0;
            end else if (forced_q) begin
                pulse_n <= 1'b1;
            end else if (cnt_inc > limit) begin
                pulse_n   <= 1'b1;
                forced_q  <= 1'b1;
                low_cnt_q <= cnt_inc;
            end else begin
                pulse_n   <= 1'b0;
                low_cnt_q <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/pulse_pace_top.sv
module pulse_pace_top
    import pulse_pace_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IVL_W = 8,
    parameter int MW_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_sync,
    input  logic [IVL_W-1:0]    cfg_interval,
    input  logic [MW_W-1:0]     cfg_maxwidth,
    input  logic [CH_NUM-1:0]   upd_strobe,
    input  logic [CH_NUM-1:0]   upd_level,
    input  logic [1:0]          opt_sel,
    input  logic                opt_data,
    output logic [CH_NUM-1:0]   pulse_n,
    output logic                opt_tx,
    output logic [CH_NUM-1:0]   fifo_ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IVL_W-1:0]        ivl_q;
    logic [MW_W-1:0]         mw_q;
    logic                    bypass;
    logic                    slot_stb;
    logic [CH_NUM*CNT_W-1:0] fifo_cnt_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= '0;
            mw_q  <= '0;
        end else if (frm_sync) begin
            ivl_q <= cfg_interval;
            mw_q  <= cfg_maxwidth;
        end
    end

    assign bypass = (ivl_q == '0);

    pace_slot_timer #(.IVL_W(IVL_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .frm_sync (frm_sync),
        .ivl_new  (cfg_interval),
        .ivl_cur  (ivl_q),
        .slot     (slot_stb)
    );

    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
        logic       strobe_ok;
        logic       head_ok;
        logic       head_level;
        pace_upd_t  apply;

        assign strobe_ok = upd_strobe[ch] && !frm_sync;
        assign apply     = pick_update(bypass, strobe_ok, upd_level[ch],
                                       slot_stb, head_ok, head_level);

        pace_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
            .clk        (clk),
            .rst        (rst),
            .clr        (frm_sync),
            .push       (strobe_ok && !bypass),
            .push_level (upd_level[ch]),
            .pop        (slot_stb),
            .head_ok    (head_ok),
            .head_level (head_level),
            .count      (fifo_cnt_all[ch*CNT_W +: CNT_W]),
            .ovf        (fifo_ovf[ch])
        );

        pulse_width_guard #(.MW_W(MW_W)) guard_i (
            .clk     (clk),
            .rst     (rst),
            .upd     (apply),
            .maxw    (mw_q),
            .pulse_n (pulse_n[ch])
        );
    end

    always_comb begin
        unique case (opt_src_e'(opt_sel))
            OPT_SRC_DATA: opt_tx = opt_data;
            OPT_SRC_CH0:  opt_tx = pulse_n[0];
            OPT_SRC_CH1:  opt_tx = pulse_n[1];
            default:      opt_tx = 1'b1;
        endcase
    end

endmodule

// File: rtl/pulse_pace_chk.sv
module pulse_pace_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int NCH   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               frm_sync,
    input logic [NCH-1:0]     upd_strobe,
    input logic [NCH-1:0]     upd_level,
    input logic               bypass,
    input logic               slot_stb,
    input logic [NCH-1:0]     pulse_n,
    input logic [NCH-1:0]     fifo_ovf,
    input logic [1:0]         opt_sel,
    input logic               opt_tx,
    input logic [NCH*CNT_W-1:0] fifo_cnt_all
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pulse_n == '1) && (fifo_ovf == '0) && (fifo_cnt_all == '0));

    // R10
    opt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (opt_sel == 2'b11) |-> opt_tx);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5
        sync_empty_chk: assert property (@(posedge clk) disable iff (rst)
            frm_sync |=> (fifo_cnt_all[g*CNT_W +: CNT_W] == '0));

        // R6
        depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
            fifo_cnt_all[g*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

        // R6
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            fifo_ovf[g] |=> fifo_ovf[g]);

        // R4
        bypass_high_chk: assert property (@(posedge clk) disable iff (rst)
            (bypass && upd_strobe[g] && upd_level[g] && !frm_sync) |=> pulse_n[g]);

        // R3
        paced_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!bypass && !slot_stb) |=> $stable(pulse_n[g]));
    end

endmodule

bind pulse_pace_top pulse_pace_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .NCH   (pulse_pace_pkg::CH_NUM)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .frm_sync     (frm_sync),
    .upd_strobe   (upd_strobe),
    .upd_level    (upd_level),
    .bypass       (bypass),
    .slot_stb     (slot_stb),
    .pulse_n      (pulse_n),
    .fifo_ovf     (fifo_ovf),
    .opt_sel      (opt_sel),
    .opt_tx       (opt_tx),
    .fifo_cnt_all (fifo_cnt_all)
);

// File: tb/pulse_pace_top_tb.sv
module pulse_pace_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_sync = 1'b0;
    logic [7:0] cfg_interval = '0;
    logic [7:0] cfg_maxwidth = '0;
    logic [1:0] upd_strobe = '0;
    logic [1:0] upd_level = '0;
    logic [1:0] opt_sel = '0;
    logic       opt_data = 1'b0;
    logic [1:0] pulse_n;
    logic       opt_tx;
    logic [1:0] fifo_ovf;

    int checks = 0;
    int errors = 0;
    logic exp0 = 1'b1;
    logic exp1 = 1'b1;

    always #4 clk = ~clk;

    pulse_pace_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .frm_sync     (frm_sync),
        .cfg_interval (cfg_interval),
        .cfg_maxwidth (cfg_maxwidth),
        .upd_strobe   (upd_strobe),
        .upd_level    (upd_level),
        .opt_sel      (opt_sel),
        .opt_data     (opt_data),
        .pulse_n      (pulse_n),
        .opt_tx       (opt_tx),
        .fifo_ovf     (fifo_ovf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one edge: inputs set at negedge, outputs read 2 ns after the posedge.
    task automatic edge_step();
        @(posedge clk);
        #2;
    endtask

    task automatic new_frame(input int ivl, input int mw);
        @(negedge clk);
        frm_sync = 1'b1;
        cfg_interval = 8'(ivl);
        cfg_maxwidth = 8'(mw);
        upd_strobe = '0;
        edge_step();
        @(negedge clk);
        frm_sync = 1'b0;
        cfg_interval = 8'hA5;  // R2: must be ignored until next sync
        cfg_maxwidth = 8'h00;
    endtask

    task automatic bypass_push(input int ch, input logic lvl);
        @(negedge clk);
        upd_strobe = 2'b00;
        upd_strobe[ch] = 1'b1;
        upd_level[ch] = lvl;
        edge_step();
        @(negedge clk);
        upd_strobe = '0;
    endtask

    // R3 R7 R9: three-update burst on both channels, check every cycle.
    task automatic paced_case(input int ivl);
        logic [2:0] l0;
        logic [2:0] l1;
        logic p0;
        logic p1;
        int span;
        l0 = 3'b010;   // index0=0 index1=1 index2=0
        l1 = 3'b001;   // index0=1 index1=0 index2=0
        p0 = exp0;
        p1 = exp1;
        span = 4 * ivl;
        new_frame(ivl, 100);
        for (int c = 1; c <= span * 4 + 2; c++) begin
            if (c <= 3) begin
                upd_strobe = 2'b11;
                upd_level = {l1[c-1], l0[c-1]};
            end else begin
                upd_strobe = 2'b00;
            end
            edge_step();
            begin
                int r;
                r = c / span;
                if (r > 3) r = 3;
                exp0 = (r == 0) ? p0 : l0[r-1];
                exp1 = (r == 0) ? p1 : l1[r-1];
            end
            check("R3 ch0 paced", 32'(pulse_n[0]), 32'(exp0));
            check("R9 ch1 paced", 32'(pulse_n[1]), 32'(exp1));
            @(negedge clk);
        end
        upd_strobe = '0;
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 during reset
        check("R1 pulse_n in reset", 32'(pulse_n), 32'h3);
        check("R1 ovf in reset", 32'(fifo_ovf), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        edge_step();
        check("R1 pulse_n after reset", 32'(pulse_n), 32'h3);
        check("R1 ovf after reset", 32'(fifo_ovf), 32'h0);

        // R4 R7: pass-through after reset (captured spacing 0)
        bypass_push(0, 1'b0);
        exp0 = 1'b0;
        check("R4 bypass low next cycle", 32'(pulse_n[0]), 32'(exp0));
        check("R9 ch1 untouched", 32'(pulse_n[1]), 32'h1);
        bypass_push(0, 1'b1);
        exp0 = 1'b1;
        check("R7 level 1 drives high", 32'(pulse_n[0]), 32'(exp0));

        // R3 R2 sweep over spacings
        for (int i = 1; i <= 5; i++) paced_case(i);

        // R8: width guard sweep in pass-through mode
        for (int m = 0; m <= 3; m++) begin
            new_frame(0, m);
            bypass_push(0, 1'b1);
            for (int k = 1; k <= 2 * m + 1; k++) begin
                bypass_push(0, 1'b0);
                check("R8 low within limit", 32'(pulse_n[0]), 32'h0);
            end
            bypass_push(0, 1'b0);
            check("R8 forced high past limit", 32'(pulse_n[0]), 32'h1);
            bypass_push(0, 1'b0);
            check("R8 held high", 32'(pulse_n[0]), 32'h1);
            bypass_push(0, 1'b1);
            check("R8 high update", 32'(pulse_n[0]), 32'h1);
            bypass_push(0, 1'b0);
            check("R8 new pulse low", 32'(pulse_n[0]), 32'h0);
            check("R9 ch1 steady", 32'(pulse_n[1]), 32'(exp1));
        end
        bypass_push(0, 1'b1);
        exp0 = 1'b1;

        // R5: sync in pass-through with a coincident strobe is discarded
        @(negedge clk);
        frm_sync = 1'b1;
        cfg_interval = 8'd0;
        cfg_maxwidth = 8'd100;
        upd_strobe = 2'b01;
        upd_level = 2'b00;
        edge_step();
        @(negedge clk);
        frm_sync = 1'b0;
        upd_strobe = '0;
        edge_step();
        check("R5 coincident strobe discarded", 32'(pulse_n[0]), 32'h1);

        // R6: overflow on ninth write, spacing 4 (slots every 16 edges)
        new_frame(4, 100);
        for (int c = 1; c <= 150; c++) begin
            if (c <= 9) begin
                upd_strobe = 2'b01;
                upd_level = {1'b0, (c % 2 == 1) ? 1'b0 : 1'b1};
            end else begin
                upd_strobe = 2'b00;
            end
            edge_step();
            if (c == 8) check("R6 no ovf at eight", 32'(fifo_ovf), 32'h0);
            if (c == 9) check("R6 ovf on ninth", 32'(fifo_ovf), 32'h1);
            if (c == 113) check("R6 seventh release", 32'(pulse_n[0]), 32'h0);
            @(negedge clk);
        end
        upd_strobe = '0;
        check("R6 ninth write dropped", 32'(pulse_n[0]), 32'h1);
        check("R6 ovf sticky", 32'(fifo_ovf), 32'h1);
        check("R9 ch1 ovf clear", 32'(fifo_ovf[1]), 32'h0);
        exp0 = 1'b1;

        // R5: a new sync empties the FIFO before its first slot
        new_frame(4, 100);
        for (int c = 1; c <= 60; c++) begin
            frm_sync = (c == 5);
            cfg_interval = 8'd4;
            upd_strobe = (c <= 3 || c == 5) ? 2'b01 : 2'b00;
            upd_level = 2'b00;
            edge_step();
            @(negedge clk);
        end
        frm_sync = 1'b0;
        upd_strobe = '0;
        check("R5 sync flushed FIFO", 32'(pulse_n[0]), 32'h1);
        check("R6 ovf still set", 32'(fifo_ovf), 32'h1);

        // R10: optical select sweep
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 2; d++) begin
                logic e;
                @(negedge clk);
                opt_sel = 2'(s);
                opt_data = d[0];
                #1;
                case (s)
                    0: e = d[0];
                    1: e = pulse_n[0];
                    2: e = pulse_n[1];
                    default: e = 1'b1;
                endcase
                check("R10 opt select", 32'(opt_tx), 32'(e));
            end
        end
        bypass_push(1, 1'b0);
        @(negedge clk);
        opt_sel = 2'd2;
        #1;
        check("R10 ch1 on opt", 32'(opt_tx), 32'h0);

        // R1: reset clears overflow
        @(negedge clk);
        rst = 1'b1;
        edge_step();
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears ovf", 32'(fifo_ovf), 32'h0);
        check("R1 reset idles outputs", 32'(pulse_n), 32'h3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule